// File: doc/BRIEF.md
# Packed Palette Write Port

This block is the host-facing write side of a color palette that stores an 8-bit red, green and blue value for every color index. The host first writes a map address, then streams 32-bit words into the data register. Each word is broken into component bytes which are stored into the palette one per clock, always in the order red, green, blue, with the entry index moving forward on its own. In packed mode a word carries four component bytes, so words straddle the 3-byte entries and the component pointer persists from one word to the next. In single-byte mode only the top byte of each word counts and every write stores exactly one component.

The same address register also selects a small indirect control file. Index 4 holds the plane read mask, and index 6 holds the overlay command byte. The host stalls on `host_ready` while earlier bytes are still being drained. A write that meets a low `host_ready` is held by the host and is never lost.

Top module: `palette_write_port`

## Requirements
- R1: In packed mode (PACKED=1) a data write stores its four bytes, most significant first, into four consecutive components. Component codes are 0 red, 1 green and 2 blue. From entry 0 the first word sets R0, G0, B0 and R1, and the second sets G1, B1, R2 and G2.
- R2: The component pointer and the entry index carry over between data writes. Within a stream each stored component follows the previous one: red to green to blue, then red of the next entry.
- R3: An address write (host_sel 0) loads the entry index and returns the component pointer to red. Packed mode takes the value from bits 7:0, single-byte mode from bits 31:24.
- R4: In single-byte mode (PACKED=0) a data write (host_sel 1) stores only bits 31:24, as one component.
- R5: After blue of entry 255 the next component is red of entry 0.
- R6: At most one palette write takes place per clock, and pal_comp is never 3 while pal_we is high.
- R7: host_ready is low while accepted bytes remain to be stored. That is 4 cycles after a packed data write and 1 cycle after a single-byte one. The store of a data write starts on the cycle after it is accepted. A write presented while host_ready is low is taken later and is not dropped.
- R8: A control write (host_sel 2) goes to the read mask when the last address written was 0x04, and to the command byte when it was 0x06. It uses the same byte lane as R3. Control writes to any other index have no effect, and so does host_sel 3.
- R9: After reset: read_mask is 0xFF, command is 0x73, host_ready is 1, pal_we is 0, and the pointer is at red of entry 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, taken when host_ready is high |
| host_sel | input | 2 | Target: 0 address, 1 data, 2 control, 3 none |
| host_data | input | 32 | Host write value |
| host_ready | output | 1 | Low while stored bytes are pending |
| pal_we | output | 1 | Palette component write enable |
| pal_idx | output | 8 | Palette entry index |
| pal_comp | output | 2 | Component select: 0 red, 1 green, 2 blue |
| pal_byte | output | 8 | Component value |
| read_mask | output | 8 | Plane read mask control byte |
| command | output | 8 | Overlay command control byte |

## Verification
The bench builds two instances with the default 8-bit index and 8-bit components. One has PACKED=1 and the other PACKED=0, and both get the same stimulus table. Address values are placed in both the low and the top byte, so each instance reaches the same entries through its own byte lane. The packed instance reaches the words that straddle entries, the wrap from entry 255 to entry 0, and the four-cycle stall. The single-byte instance reaches the ignoring of the lower three bytes and the one-cycle stall.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
   typedef enum logic [1:0] {COMP_R = 2'd0, COMP_G = 2'd1, COMP_B = 2'd2} comp_e;
   typedef enum logic [1:0] {SEL_ADDR = 2'd0, SEL_DATA = 2'd1, SEL_CTRL = 2'd2, SEL_NONE = 2'd3} sel_e;
endpackage

// File: rtl/pwp_byte_queue.sv
module pwp_byte_queue #(
   parameter int COMP_W = 8,
   parameter int WORD_W = 32,
   localparam int LANES = WORD_W / COMP_W,
   localparam int CNT_W = $clog2(LANES + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_cnt,
   input  logic [WORD_W-1:0] load_word,
   output logic              valid,
   output logic [COMP_W-1:0] head
);
   logic [WORD_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (load) begin
         shreg <= load_word;
         cnt   <= load_cnt;
      end else if (cnt != '0) begin
         shreg <= shreg << COMP_W;
         cnt   <= cnt - CNT_W'(1);
      end
   end

   assign valid = (cnt != '0);
   assign head  = shreg[WORD_W-1 -: COMP_W];
endmodule

// File: rtl/pwp_cursor.sv
module pwp_cursor
   import pwp_pkg::*;
#(
   parameter int IDX_W = 8
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set,
   input  logic [IDX_W-1:0] set_idx,
   input  logic             step,
   output logic [IDX_W-1:0] idx,
   output comp_e            comp
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx  <= '0;
         comp <= COMP_R;
      end else if (set) begin
         idx  <= set_idx;
         comp <= COMP_R;
      end else if (step) begin
         unique case (comp)
            COMP_R:  comp <= COMP_G;
            COMP_G:  comp <= COMP_B;
            default: begin
               comp <= COMP_R;
               idx  <= idx + IDX_W'(1);
            end
         endcase
      end
   end
endmodule

// File: rtl/pwp_ctrl_regs.sv
module pwp_ctrl_regs #(
   parameter int             IDX_W     = 8,
   parameter int             COMP_W    = 8,
   parameter int             MASK_SLOT = 4,
   parameter int             CMD_SLOT  = 6,
   parameter logic [COMP_W-1:0] MASK_INIT = '1,
   parameter logic [COMP_W-1:0] CMD_INIT  = 8'h73
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              slot_wr,
   input  logic [IDX_W-1:0]  slot_val,
   input  logic              reg_wr,
   input  logic [COMP_W-1:0] reg_val,
   output logic [COMP_W-1:0] mask_q,
   output logic [COMP_W-1:0] cmd_q
);
   localparam logic [IDX_W-1:0] MASK_IDX = IDX_W'(MASK_SLOT);
   localparam logic [IDX_W-1:0] CMD_IDX  = IDX_W'(CMD_SLOT);

   logic [IDX_W-1:0] slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
         mask_q <= MASK_INIT;
         cmd_q  <= CMD_INIT;
      end else begin
         if (slot_wr) slot_q <= slot_val;
         if (reg_wr && slot_q == MASK_IDX) mask_q <= reg_val;
         if (reg_wr && slot_q == CMD_IDX)  cmd_q  <= reg_val;
      end
   end
endmodule

// File: rtl/palette_write_port.sv
module palette_write_port
   import pwp_pkg::*;
#(
   parameter int IDX_W     = 8,
   parameter int COMP_W    = 8,
   parameter int WORD_W    = 32,
   parameter bit PACKED    = 1'b1,
   parameter int MASK_SLOT = 4,
   parameter int CMD_SLOT  = 6,
   parameter logic [COMP_W-1:0] MASK_INIT = '1,
   parameter logic [COMP_W-1:0] CMD_INIT  = 8'h73
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [1:0]        host_sel,
   input  logic [WORD_W-1:0] host_data,
   output logic              host_ready,
   output logic              pal_we,
   output logic [IDX_W-1:0]  pal_idx,
   output logic [1:0]        pal_comp,
   output logic [COMP_W-1:0] pal_byte,
   output logic [COMP_W-1:0] read_mask,
   output logic [COMP_W-1:0] command
);
   localparam int LANES = WORD_W / COMP_W;
   localparam int CNT_W = $clog2(LANES + 1);

   generate
      if (WORD_W % COMP_W != 0) begin : g_bad_lanes
         $error("WORD_W must be a whole number of components");
      end
      if (IDX_W < 3 || MASK_SLOT == CMD_SLOT) begin : g_bad_slots
         $error("control slots must be distinct and addressable");
      end
      if (MASK_SLOT >= (1 << IDX_W) || CMD_SLOT >= (1 << IDX_W)) begin : g_bad_range
         $error("control slot outside the index range");
      end
   endgenerate

   logic              accept;
   logic [COMP_W-1:0] lane_byte;
   logic [WORD_W-1:0] q_word;
   logic [CNT_W-1:0]  q_cnt;
   logic              q_valid;
   comp_e             cur_comp;

   assign accept = host_wr && host_ready;

   generate
      if (PACKED) begin : g_packed
         assign lane_byte = host_data[COMP_W-1:0];
         assign q_word    = host_data;
         assign q_cnt     = CNT_W'(LANES);
      end else begin : g_single
         assign lane_byte = host_data[WORD_W-1 -: COMP_W];
         assign q_word    = WORD_W'(lane_byte) << (WORD_W - COMP_W);
         assign q_cnt     = CNT_W'(1);
      end
   endgenerate

   pwp_byte_queue #(.COMP_W(COMP_W), .WORD_W(WORD_W)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept && host_sel == SEL_DATA),
      .load_cnt  (q_cnt),
      .load_word (q_word),
      .valid     (q_valid),
      .head      (pal_byte)
   );

   pwp_cursor #(.IDX_W(IDX_W)) u_cursor (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (accept && host_sel == SEL_ADDR),
      .set_idx (lane_byte[IDX_W-1:0]),
      .step    (q_valid),
      .idx     (pal_idx),
      .comp    (cur_comp)
   );

   pwp_ctrl_regs #(
      .IDX_W(IDX_W), .COMP_W(COMP_W), .MASK_SLOT(MASK_SLOT), .CMD_SLOT(CMD_SLOT),
      .MASK_INIT(MASK_INIT), .CMD_INIT(CMD_INIT)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .slot_wr  (accept && host_sel == SEL_ADDR),
      .slot_val (lane_byte[IDX_W-1:0]),
      .reg_wr   (accept && host_sel == SEL_CTRL),
      .reg_val  (lane_byte),
      .mask_q   (read_mask),
      .cmd_q    (command)
   );

   assign host_ready = !q_valid;
   assign pal_we     = q_valid;
   assign pal_comp   = cur_comp;
endmodule

// File: rtl/pwp_checker.sv
module pwp_checker #(
   parameter int IDX_W  = 8,
   parameter int COMP_W = 8,
   parameter int WORD_W = 32,
   parameter bit PACKED = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic              host_wr,
   input logic [1:0]        host_sel,
   input logic [WORD_W-1:0] host_data,
   input logic              host_ready,
   input logic              pal_we,
   input logic [IDX_W-1:0]  pal_idx,
   input logic [1:0]        pal_comp,
   input logic [COMP_W-1:0] read_mask,
   input logic [COMP_W-1:0] command
);
   logic [IDX_W-1:0] chk_lane;
   assign chk_lane = PACKED ? host_data[IDX_W-1:0] : host_data[WORD_W-1 -: IDX_W];

   assert_comp_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pal_we |-> pal_comp != 2'd3);

   assert_data_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_ready && host_sel == 2'd1) |=> pal_we);

   assert_stall_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pal_we |-> !host_ready);

   assert_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pal_we && $past(pal_we) && $past(pal_comp) != 2'd2)
      |-> (pal_idx == $past(pal_idx) && pal_comp == 2'($past(pal_comp) + 2'd1)));

   assert_next_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pal_we && $past(pal_we) && $past(pal_comp) == 2'd2)
      |-> (pal_comp == 2'd0 && pal_idx == IDX_W'($past(pal_idx) + 1'b1)));

   assert_addr_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && host_ready && host_sel == 2'd0) |=> (pal_idx == $past(chk_lane) && pal_comp == 2'd0));

   assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(host_wr && host_ready && host_sel == 2'd2) |=> ($stable(read_mask) && $stable(command)));
endmodule

bind palette_write_port pwp_checker #(
   .IDX_W(IDX_W), .COMP_W(COMP_W), .WORD_W(WORD_W), .PACKED(PACKED)
) u_pwp_checker (
   .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
   .host_data(host_data), .host_ready(host_ready), .pal_we(pal_we),
   .pal_idx(pal_idx), .pal_comp(pal_comp), .read_mask(read_mask), .command(command)
);

// File: tb/test_palette_write_port.sv
module test_palette_write_port;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic        hw[2];
   logic [1:0]  hsel[2];
   logic [31:0] hdat[2];
   logic        rdy[2];
   logic        we_o[2];
   logic [7:0]  idx_o[2];
   logic [1:0]  comp_o[2];
   logic [7:0]  byte_o[2];
   logic [7:0]  mask_o[2];
   logic [7:0]  cmd_o[2];

   palette_write_port #(.PACKED(1'b1)) i_palette_write_port (
      .clk(clk), .rst_n(rst_n), .host_wr(hw[0]), .host_sel(hsel[0]), .host_data(hdat[0]),
      .host_ready(rdy[0]), .pal_we(we_o[0]), .pal_idx(idx_o[0]), .pal_comp(comp_o[0]),
      .pal_byte(byte_o[0]), .read_mask(mask_o[0]), .command(cmd_o[0]));

   palette_write_port #(.PACKED(1'b0)) i_palette_write_port_single (
      .clk(clk), .rst_n(rst_n), .host_wr(hw[1]), .host_sel(hsel[1]), .host_data(hdat[1]),
      .host_ready(rdy[1]), .pal_we(we_o[1]), .pal_idx(idx_o[1]), .pal_comp(comp_o[1]),
      .pal_byte(byte_o[1]), .read_mask(mask_o[1]), .command(cmd_o[1]));

   // Palette RAM stand-in, layout {red, green, blue}
   logic [23:0] cap0[256];
   logic [23:0] cap1[256];
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int e = 0; e < 256; e++) begin cap0[e] <= '0; cap1[e] <= '0; end
      end else begin
         if (we_o[0]) cap0[idx_o[0]][(2 - comp_o[0]) * 8 +: 8] <= byte_o[0];
         if (we_o[1]) cap1[idx_o[1]][(2 - comp_o[1]) * 8 +: 8] <= byte_o[1];
      end
   end

   // Shadow model built from the requirements
   logic [23:0] shadow[2][256];
   int          m_idx[2];
   int          m_comp[2];
   int          m_slot[2];
   logic [7:0]  m_mask[2];
   logic [7:0]  m_cmd[2];

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // {sel, data}; address values sit in both byte lanes
   localparam int NSTIM = 14;
   localparam logic [33:0] STIM [NSTIM] = '{
      {2'd0, 32'h0000_0000}, {2'd1, 32'h1122_3344}, {2'd1, 32'h5566_7788},
      {2'd0, 32'hFE00_00FE}, {2'd1, 32'hA1A2_A3A4}, {2'd1, 32'hB1B2_B3B4},
      {2'd1, 32'hC1C2_C3C4}, {2'd0, 32'h1000_0010}, {2'd1, 32'hD0D1_D2D3},
      {2'd0, 32'h2000_0020}, {2'd1, 32'hE0E1_E2E3}, {2'd3, 32'hDEAD_BEEF},
      {2'd1, 32'hF0F1_F2F3}, {2'd1, 32'h0908_0706}
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic model_wr(input int d, input logic [1:0] s, input logic [31:0] v);
      logic [7:0] lane;
      lane = (d == 0) ? v[7:0] : v[31:24];
      if (s == 2'd0) begin
         m_idx[d] = lane; m_comp[d] = 0; m_slot[d] = lane;
      end else if (s == 2'd2) begin
         if (m_slot[d] == 4) m_mask[d] = lane;
         if (m_slot[d] == 6) m_cmd[d]  = lane;
      end else if (s == 2'd1) begin
         for (int k = 0; k < ((d == 0) ? 4 : 1); k++) begin
            shadow[d][m_idx[d]][(2 - m_comp[d]) * 8 +: 8] = v[31 - 8 * k -: 8];
            if (m_comp[d] == 2) begin m_comp[d] = 0; m_idx[d] = (m_idx[d] + 1) % 256; end
            else m_comp[d] = m_comp[d] + 1;
         end
      end
   endtask

   // Starts and ends at a falling edge; holds the write while host_ready is low
   task automatic host_wr(input int d, input logic [1:0] s, input logic [31:0] v);
      hw[d] = 1'b1; hsel[d] = s; hdat[d] = v;
      while (!rdy[d]) @(negedge clk);
      @(negedge clk);
      hw[d] = 1'b0;
      model_wr(d, s, v);
   endtask

   task automatic drain();
      repeat (6) @(negedge clk);
   endtask

   task automatic compare_maps(input string req);
      for (int e = 0; e < 256; e++) begin
         check(cap0[e] == shadow[0][e], {req, " packed entry"}, cap0[e], shadow[0][e]);
         check(cap1[e] == shadow[1][e], {req, " single entry"}, cap1[e], shadow[1][e]);
      end
   endtask

   task automatic stall_len(input int d, input logic [31:0] v, input int exp);
      int n;
      hw[d] = 1'b1; hsel[d] = 2'd1; hdat[d] = v;
      @(negedge clk);
      hw[d] = 1'b0;
      model_wr(d, 2'd1, v);
      n = 0;
      while (!rdy[d] && n < 20) begin
         check(we_o[d] == 1'b1, "R7 store during stall", 32'(we_o[d]), 32'd1);
         n++;
         @(negedge clk);
      end
      check(n == exp, "R7 stall length", n, exp);
   endtask

   initial begin
      for (int d = 0; d < 2; d++) begin
         hw[d] = 1'b0; hsel[d] = 2'd0; hdat[d] = '0;
         m_idx[d] = 0; m_comp[d] = 0; m_slot[d] = 0; m_mask[d] = 8'hFF; m_cmd[d] = 8'h73;
         for (int e = 0; e < 256; e++) shadow[d][e] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9 reset state
      for (int d = 0; d < 2; d++) begin
         check(mask_o[d] == 8'hFF, "R9 read_mask", mask_o[d], 8'hFF);
         check(cmd_o[d] == 8'h73, "R9 command", cmd_o[d], 8'h73);
         check(rdy[d] == 1'b1 && we_o[d] == 1'b0, "R9 ready/we", {rdy[d], we_o[d]}, 2'b10);
         check(idx_o[d] == 8'd0 && comp_o[d] == 2'd0, "R9 pointer", {idx_o[d], comp_o[d]}, 0);
      end

      // R1 first word straddles entries 0 and 1
      host_wr(0, 2'd0, 32'h0);
      host_wr(0, 2'd1, 32'hAABB_CCDD);
      drain();
      check(cap0[0] == 24'hAABBCC && cap0[1][23:16] == 8'hDD, "R1 first word",
            {cap0[0], cap0[1][23:16]}, 32'hAABBCCDD);

      // Table: R1 R2 R3 R4 R5 R8 (sel 3 ignored) on both modes
      for (int i = 0; i < NSTIM; i++) begin
         host_wr(0, STIM[i][33:32], STIM[i][31:0]);
         host_wr(1, STIM[i][33:32], STIM[i][31:0]);
      end
      drain();
      compare_maps("R1/R2/R3/R4/R5");
      for (int d = 0; d < 2; d++)
         check(idx_o[d] == 8'(m_idx[d]) && comp_o[d] == 2'(m_comp[d]), "R2 pointer kept",
               {idx_o[d], comp_o[d]}, {8'(m_idx[d]), 2'(m_comp[d])});

      // R5 wrap from blue of 255 to red of 0
      host_wr(0, 2'd0, 32'h0000_00FF);
      host_wr(0, 2'd1, 32'h0102_0304);
      drain();
      check(cap0[255] == 24'h010203 && cap0[0][23:16] == 8'h04, "R5 wrap",
            {cap0[255], cap0[0][23:16]}, 32'h01020304);
      check(idx_o[0] == 8'd0 && comp_o[0] == 2'd1, "R5 pointer after wrap", {idx_o[0], comp_o[0]}, 10'h001);

      // R7 stall lengths, and back-to-back writes not dropped
      stall_len(0, 32'h4142_4344, 4);
      stall_len(1, 32'h5152_5354, 1);
      host_wr(0, 2'd1, 32'h6162_6364);
      host_wr(0, 2'd1, 32'h7172_7374);
      host_wr(1, 2'd1, 32'h8182_8384);
      host_wr(1, 2'd1, 32'h9192_9394);
      drain();
      compare_maps("R7 R4");

      // R8 control file
      for (int d = 0; d < 2; d++) begin
         host_wr(d, 2'd0, 32'h0600_0006);
         host_wr(d, 2'd2, 32'h7000_0070);
         host_wr(d, 2'd0, 32'h0400_0004);
         host_wr(d, 2'd2, 32'h0000_0000);
         @(negedge clk);
         check(cmd_o[d] == 8'h70, "R8 command blank", cmd_o[d], 8'h70);
         check(mask_o[d] == 8'h00, "R8 read_mask blank", mask_o[d], 8'h00);
         host_wr(d, 2'd0, 32'h0500_0005);
         host_wr(d, 2'd2, 32'h5500_0055);
         host_wr(d, 2'd3, 32'hFFFF_FFFF);
         @(negedge clk);
         check(mask_o[d] == m_mask[d] && cmd_o[d] == m_cmd[d], "R8 other slot ignored",
               {mask_o[d], cmd_o[d]}, {m_mask[d], m_cmd[d]});
         host_wr(d, 2'd0, 32'h0600_0006);
         host_wr(d, 2'd2, 32'h7300_0073);
         @(negedge clk);
         check(cmd_o[d] == 8'h73, "R8 command restore", cmd_o[d], 8'h73);
      end

      // R6 no stray palette writes after idle
      drain();
      check(we_o[0] == 1'b0 && we_o[1] == 1'b0, "R6 idle", {we_o[0], we_o[1]}, 0);
      compare_maps("R6/R8 map untouched");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule